// File: doc/BRIEF.md
# Float to Integer Converter with Selectable Language Semantics

This block turns one IEEE754 operand, single or double precision, into a 32-bit or 64-bit integer, signed or unsigned, within a single registered cycle. A 3-bit mode picks where the rounding direction comes from. It is either the 2-bit rounding field of the floating-point status register or fixed truncation. The mode also picks how values the destination cannot hold are treated.

There are three treatments for out-of-range values. Two of them clamp to the nearest representable limit: one sends NaN to the destination minimum, the other sends NaN to zero. The third reduces the rounded value modulo 2^N and sends infinities and NaN to zero. Invalid and inexact flags come out beside the result. An illegal-mode flag marks the two unused mode codes. The block sits in an execution pipe, and its output register is the only stage.

Top module: `fp2int_conv`

## Requirements
- R1: Mode bit 0 set forces truncation toward zero. With mode bit 0 clear, the rounding direction comes from `in_rm`.
- R2: The `in_rm` encoding is 00 round to nearest with ties to even, 01 toward zero, 10 toward +infinity, and 11 toward -infinity.
- R3: Modes 000 to 011 clamp. A rounded value below the destination minimum gives the minimum, and one above the maximum gives the maximum. The limits are -2^(N-1) and 2^(N-1)-1 for signed destinations and 0 and 2^N-1 for unsigned ones. A negative value bound for an unsigned destination that does not round to zero gives 0. An infinity clamps by its sign.
- R4: A NaN operand gives the destination minimum under modes 000 and 001, and gives 0 under modes 010 and 011.
- R5: Modes 100 and 101 reduce the rounded integer modulo 2^N and read the result as two's complement when the destination is signed. An infinity or NaN operand gives 0 under these modes.
- R6: Modes 110 and 111 set `out_illegal`. The result is 0, and the invalid and inexact flags stay clear.
- R7: `in_single` selects a single-precision operand in `in_op[31:0]`. When it is clear, the operand is double precision in `in_op[63:0]`. Subnormal operands convert as nonzero values of magnitude below one half.
- R8: A 32-bit result is sign-extended to 64 bits for a signed destination and zero-extended for an unsigned one.
- R9: `out_invalid` is set for every NaN operand in a legal mode. It is also set for every operand that is clamped under modes 000 to 011. An infinity under modes 100 and 101 does not set it.
- R10: `out_inexact` is set when rounding drops nonzero fraction bits and `out_invalid` is clear.
- R11: Results and flags appear one clock after an `in_valid` cycle, with `out_valid` high. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | Floating-point operand |
| in_single | input | 1 | 1: operand is single precision in bits 31:0 |
| in_dw64 | input | 1 | 1: 64-bit destination, 0: 32-bit |
| in_signed | input | 1 | 1: signed destination |
| in_mode | input | 3 | Rounding source and out-of-range policy |
| in_rm | input | 2 | Status-register rounding mode |
| out_valid | output | 1 | Result strobe |
| out_value | output | 64 | Integer result |
| out_illegal | output | 1 | Unused mode code seen |
| out_invalid | output | 1 | NaN or clamped conversion |
| out_inexact | output | 1 | Fraction discarded by rounding |

## Verification
Rounding and range clamping can act on the same operand in one cycle. A rounding increment can carry a value that lies just inside a limit to one past it. The sweep provokes this with operands such as 2^31-1 plus three quarters and 2^32-1 plus three quarters, under every rounding direction and every destination type. The bench then judges whether the result is the rounded value or the clamped limit, and whether invalid or inexact is reported, from integer arithmetic on the exact operand value.

// File: rtl/fp2int_conv.sv
module fp2int_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_op,
  input  logic        in_single,
  input  logic        in_dw64,
  input  logic        in_signed,
  input  logic [2:0]  in_mode,
  input  logic [1:0]  in_rm,
  output logic        out_valid,
  output logic [63:0] out_value,
  output logic        out_illegal,
  output logic        out_invalid,
  output logic        out_inexact
);

  logic               sgn, top_exp, zero_exp, frac_zero;
  logic        [52:0] mant;
  logic signed [12:0] e;

  always_comb begin
    if (in_single) begin
      sgn       = in_op[31];
      top_exp   = &in_op[30:23];
      zero_exp  = in_op[30:23] == 8'd0;
      frac_zero = in_op[22:0] == 23'd0;
      mant      = {~zero_exp, in_op[22:0], 29'd0};
      e         = $signed({5'd0, in_op[30:23]}) - 13'sd127;
    end else begin
      sgn       = in_op[63];
      top_exp   = &in_op[62:52];
      zero_exp  = in_op[62:52] == 11'd0;
      frac_zero = in_op[51:0] == 52'd0;
      mant      = {~zero_exp, in_op[51:0]};
      e         = $signed({2'd0, in_op[62:52]}) - 13'sd1023;
    end
    if (zero_exp) e = -13'sd2000;
  end

  wire is_nan = top_exp & ~frac_zero;
  wire is_inf = top_exp & frac_zero;
  wire big    = ~top_exp & (e >= 13'sd64);

  logic [127:0] fx;
  always_comb begin
    if (e < -13'sd12)      fx = {127'd0, |mant};
    else if (e < 13'sd64)  fx = {75'd0, mant} << 7'(e + 13'sd12);
    else                   fx = 128'd0;
  end

  wire [63:0] ip  = fx[127:64];
  wire        rb  = fx[63];
  wire        st  = |fx[62:0];
  wire [1:0]  rmd = in_mode[0] ? 2'b01 : in_rm;

  logic inc;
  always_comb begin
    case (rmd)
      2'b00:   inc = rb & (st | ip[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = ~sgn & (rb | st);
      default: inc = sgn & (rb | st);
    endcase
  end

  wire [64:0] mag = {1'b0, ip} + {64'd0, inc};

  wire [63:0] modb    = (e < 13'sd116) ? ({11'd0, mant} << 6'(e - 13'sd52)) : 64'd0;
  wire [63:0] mod_mag = big ? modb : mag[63:0];
  wire [63:0] mod_neg = sgn ? -mod_mag : mod_mag;
  wire [63:0] modv    = in_dw64   ? mod_neg :
                        in_signed ? {{32{mod_neg[31]}}, mod_neg[31:0]} :
                                    {32'd0, mod_neg[31:0]};

  wire [64:0] lim = in_signed ? ((in_dw64 ? {1'b0, 64'h8000_0000_0000_0000}
                                          : {33'd0, 32'h8000_0000}) - {64'd0, ~sgn})
                              : (sgn ? 65'd0 : (in_dw64 ? {1'b0, {64{1'b1}}} : {33'd0, {32{1'b1}}}));
  wire        ovf  = is_inf | big | (mag > lim);
  wire [63:0] maxv = in_signed ? (in_dw64 ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF)
                               : (in_dw64 ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF);
  wire [63:0] minv = in_signed ? (in_dw64 ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000)
                               : 64'd0;
  wire [63:0] satv = is_nan ? (in_mode[1] ? 64'd0 : minv) :
                     ovf    ? (sgn ? minv : maxv) :
                     (sgn ? -mag[63:0] : mag[63:0]);

  wire        modular = in_mode[2];
  wire        illegal = in_mode[2] & in_mode[1];
  wire [63:0] res = illegal ? 64'd0 : modular ? ((is_nan | is_inf) ? 64'd0 : modv) : satv;
  wire        inv = ~illegal & (is_nan | (~modular & ovf));
  wire        inx = ~illegal & ~inv & ~is_inf & (rb | st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_value   <= 64'd0;
      out_illegal <= 1'b0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_value   <= res;
      out_illegal <= illegal;
      out_invalid <= inv;
      out_inexact <= inx;
    end
  end

  p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_value == 64'd0 && !out_invalid && !out_inexact));
  p_illegal_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode[2:1] == 2'b11) |=> out_illegal);
  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_invalid && out_inexact));
  p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_sext32_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_signed && !in_dw64) |=> (out_value[63:32] == {32{out_value[31]}}));
  p_zext32_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_signed && !in_dw64) |=> (out_value[63:32] == 32'd0));
  p_nan_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nan && !illegal) |=> out_invalid);

endmodule

// File: tb/fp2int_conv_test.sv
`timescale 1ns/1ps
module fp2int_conv_test;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [63:0] in_op = '0;
  logic in_single = 1'b0, in_dw64 = 1'b0, in_signed = 1'b0;
  logic [2:0] in_mode = '0;
  logic [1:0] in_rm = '0;
  logic out_valid, out_illegal, out_invalid, out_inexact;
  logic [63:0] out_value;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp2int_conv uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_single(in_single), .in_dw64(in_dw64), .in_signed(in_signed), .in_mode(in_mode),
    .in_rm(in_rm), .out_valid(out_valid), .out_value(out_value), .out_illegal(out_illegal),
    .out_invalid(out_invalid), .out_inexact(out_inexact));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h (op %h sgl %0d dw64 %0d sgn %0d mode %0d rm %0d)",
               req, act, exp, in_op, in_single, in_dw64, in_signed, in_mode, in_rm);
    end
  endtask

  function automatic logic [127:0] kval(input int i);
    case (i)
      0: return 128'd0;           1: return 128'd1;
      2: return 128'd2;           3: return 128'd3;
      4: return 128'd127;         5: return 128'd128;
      6: return (128'd1 << 31) - 1;  7: return 128'd1 << 31;
      8: return (128'd1 << 32) - 1;  9: return 128'd1 << 32;
      10: return 128'd1 << 52;    11: return (128'd1 << 53) - 1;
      12: return 128'd1 << 63;    13: return 128'd1 << 64;
      14: return 128'd1 << 70;    15: return (128'd1 << 63) - 2048;
      default: return (128'd1 << 64) - 2048;
    endcase
  endfunction

  // f: 0 exact, 1 below half, 2 exactly half, 3 above half
  task automatic model(input logic s, input logic [127:0] k, input int f, input bit nan,
                       input bit inf, output logic [63:0] val, output logic ill,
                       output logic inv, output logic inx);
    logic [1:0] rmd;
    logic signed [129:0] r, v, lo, hi;
    int n;
    ill = 0; inv = 0; inx = 0; val = 0;
    if (in_mode[2:1] == 2'b11) begin ill = 1; return; end
    rmd = in_mode[0] ? 2'b01 : in_rm;   // R1
    r = $signed({2'b0, k});
    case (rmd)                          // R2
      2'b00: if (f == 3 || (f == 2 && k[0])) r = r + 1;
      2'b10: if (!s && f != 0) r = r + 1;
      2'b11: if (s && f != 0) r = r + 1;
      default: ;
    endcase
    v = s ? -r : r;
    n = in_dw64 ? 64 : 32;
    lo = in_signed ? -(130'sd1 <<< (n - 1)) : 130'sd0;
    hi = in_signed ? (130'sd1 <<< (n - 1)) - 1 : (130'sd1 <<< n) - 1;
    if (in_mode[2]) begin
      if (nan) inv = 1;
      else if (!inf) begin
        inx = f != 0;
        if (n == 64) val = v[63:0];
        else val = in_signed ? {{32{v[31]}}, v[31:0]} : {32'd0, v[31:0]};
      end
    end else begin
      if (nan) begin inv = 1; val = in_mode[1] ? 64'd0 : lo[63:0]; end
      else if (inf) begin inv = 1; val = s ? lo[63:0] : hi[63:0]; end
      else if (v < lo) begin inv = 1; val = lo[63:0]; end
      else if (v > hi) begin inv = 1; val = hi[63:0]; end
      else begin val = v[63:0]; inx = f != 0; end
    end
  endtask

  task automatic run(input logic [63:0] op, input logic s, input logic [127:0] k,
                     input int f, input bit nan, input bit inf);
    logic [63:0] ev; logic ei, ev_inv, ex;
    string req;
    @(negedge clk);
    in_op = op; in_valid = 1'b1;
    model(s, k, f, nan, inf, ev, ei, ev_inv, ex);
    @(posedge clk); #1;
    if (ei) req = "R6";
    else if (nan) req = in_mode[2] ? "R5" : "R4";
    else if (in_mode[2]) req = "R5";
    else if (ev_inv) req = "R3";
    else if (!in_dw64) req = "R8";
    else if (in_single) req = "R7";
    else req = in_mode[0] ? "R1" : "R2";
    chk(req, out_value, ev);
    chk("R6", {63'd0, out_illegal}, {63'd0, ei});
    chk("R9", {63'd0, out_invalid}, {63'd0, ev_inv});
    chk("R10", {63'd0, out_inexact}, {63'd0, ex});
    chk("R11", {63'd0, out_valid}, 64'd1);
  endtask

  initial begin
    logic [63:0] d, sb;
    logic [127:0] k;
    int ee;
    real r;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", {out_valid, out_illegal, out_invalid, out_inexact}, 64'd0);
    chk("R11", out_value, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 17; i++)
      for (int q = 0; q < 4; q++)
        for (int s = 0; s < 2; s++) begin
          k = kval(i);
          if (q != 0 && k >= (128'd1 << 50)) continue;
          r = 0.0;
          for (int b = 127; b >= 0; b--) r = r * 2.0 + (k[b] ? 1.0 : 0.0);
          r = r + q / 4.0;
          if (s != 0) r = -r;
          d = $realtobits(r);
          ee = int'(d[62:52]) - 1023;
          for (int sg = 0; sg < 2; sg++) begin
            if (sg != 0) begin
              if (d[62:0] == 63'd0) sb = {32'd0, d[63], 31'd0};
              else if (ee < -126 || ee > 127 || d[28:0] != 29'd0) continue;
              else sb = {32'd0, d[63], 8'(ee + 127), d[51:29]};
            end else sb = d;
            for (int m = 0; m < 32; m++)
              for (int rm = 0; rm < 4; rm++) begin
                in_single = sg[0]; in_dw64 = m[4]; in_signed = m[3];
                in_mode = m[2:0]; in_rm = rm[1:0];
                run(sb, s[0], k, q, 0, 0);
              end
          end
        end
    // specials: infinities, NaNs, subnormals (R7 subnormal = tiny nonzero)
    for (int t = 0; t < 6; t++)
      for (int sg = 0; sg < 2; sg++)
        for (int m = 0; m < 32; m++)
          for (int rm = 0; rm < 4; rm++) begin
            logic [63:0] op;
            logic s;
            bit nan, inf;
            s = t[0];
            nan = (t / 2) == 1; inf = (t / 2) == 0;
            case (t / 2)
              0: op = sg ? {32'd0, s, 31'h7F80_0000} : {s, 63'h7FF0_0000_0000_0000};
              1: op = sg ? {32'd0, s, 31'h7FC0_0000} : {s, 63'h7FF8_0000_0000_0000};
              default: op = sg ? {32'd0, s, 31'd1} : {s, 63'd1};
            endcase
            in_single = sg[0]; in_dw64 = m[4]; in_signed = m[3];
            in_mode = m[2:0]; in_rm = rm[1:0];
            run(op, s, 128'd0, (t / 2) == 2 ? 1 : 0, nan, inf);
          end
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R11", {63'd0, out_valid}, 64'd0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done) begin
        done = 1;
        checks++; errors++;
        $display("FAIL watchdog actual %0d expected below 190000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule